// File: doc/BRIEF.md
# Periodic Wake-Up Timer

A free-running periodic timer for a bus-attached peripheral slot. Software programs a 16-bit reload value and turns the timer on through an 8-bit control word. From then on a down-counter runs on the selected count clock, and each completed period sets a sticky flag. The flag drives an interrupt request when interrupts are enabled, and software clears it by writing a one to it.

The count clock is either a dedicated slow clock input or the bus clock itself. The slow clock is sampled in the bus domain, and each of its rising edges becomes a one-cycle count tick. The clock choice is frozen while the timer runs.

An optional external output shows one of two waveforms. The first is a one-tick pulse at the end of every period. The second is a square wave that changes level at every timeout.

Top module: `periodic_wakeup_timer`

## Requirements
- R1: After reset the control word (address 0) and the reload register (address 1) read 0, and `irq_o` and `ext_o` are low. The control fields sit in these bits: 7 count-clock select (1 = bus clock, 0 = slow clock), 4 waveform select, 3 external-output enable, 2 run, 1 interrupt enable, 0 flag. Bits 6, 5 and 15:8 always read 0.
- R2: The count-clock select changes only on a control write made while run is 0 that also leaves bit 2 at 0. Any other control write leaves it unchanged.
- R3: With the bus clock selected and reload value R, the first timeout comes 2*(R+1) cycles after the clock edge that sets run. Later timeouts follow every 2*(R+1) cycles.
- R4: With the slow clock selected, a period lasts 2*(R+1) rising edges of `slow_clk`.
- R5: The flag stays 1 until a control write with bit 0 = 1 clears it. A control write with bit 0 = 0 leaves it unchanged.
- R6: When a timeout and a flag-clearing write fall on the same edge, the flag ends up 1.
- R7: `irq_o` is high exactly when both the flag and the interrupt enable are 1.
- R8: `ext_o` stays low unless both the external-output enable and run are 1.
- R9: With waveform select 0, `ext_o` goes high for one count tick after each timeout. With the bus clock that is one cycle.
- R10: With waveform select 1, `ext_o` starts low when run is set and toggles at each timeout.
- R11: While run is 0 the counter holds the reload value and no timeout occurs. Each time run is set, a full period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Dedicated slow count clock, sampled in the bus domain |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = control word, 1 = reload register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |
| ext_o | output | 1 | External waveform output |

## Verification
The one collision in this block is a timeout setting the flag on the same edge that software writes a one to clear it. The bench provokes it with reload 0 on the bus clock, which puts timeouts on every second edge counted from the enabling write. It then aims a clear write at one of those timeout edges and expects the flag to read 1 afterwards. A second clear, placed on the edge between timeouts, must then read 0, which shows that the clear path itself works.

// File: rtl/periodic_wakeup_timer.sv
module periodic_wakeup_timer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              ext_o
);

  logic clk_sel, wave_sel, ext_en, run, irq_en, flag;
  logic [CNT_W-1:0] reload_q, cnt;
  logic phase, pulse, sq;
  logic [SYNC_N:0] slow_sync;

  wire ctrl_wr   = bus_wr && !bus_addr;
  wire reload_wr = bus_wr && bus_addr;
  wire slow_tick = slow_sync[SYNC_N-1] && !slow_sync[SYNC_N];
  wire tick      = clk_sel ? 1'b1 : slow_tick;
  wire at_zero   = (cnt == '0);
  wire timeout   = run && tick && at_zero && phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slow_sync <= '0;
    else        slow_sync <= {slow_sync[SYNC_N-1:0], slow_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel  <= 1'b0;
      wave_sel <= 1'b0;
      ext_en   <= 1'b0;
      run      <= 1'b0;
      irq_en   <= 1'b0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        wave_sel <= bus_wdata[4];
        ext_en   <= bus_wdata[3];
        run      <= bus_wdata[2];
        irq_en   <= bus_wdata[1];
        if (!run && !bus_wdata[2]) clk_sel <= bus_wdata[7];
      end
      if (reload_wr) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          flag <= 1'b0;
    else if (timeout)                    flag <= 1'b1;
    else if (ctrl_wr && bus_wdata[0])    flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
      pulse <= 1'b0;
      sq    <= 1'b0;
    end else if (!run) begin
      cnt   <= reload_q;
      phase <= 1'b0;
      pulse <= 1'b0;
      sq    <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        cnt   <= reload_q;
        phase <= !phase;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
      pulse <= timeout;
      if (timeout) sq <= !sq;
    end
  end

  assign bus_rdata = bus_addr ? DATA_W'(reload_q)
                              : DATA_W'({clk_sel, 2'b00, wave_sel, ext_en, run, irq_en, flag});
  assign irq_o = flag && irq_en;
  assign ext_o = ext_en && run && (wave_sel ? sq : pulse);

  p_clk_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(clk_sel));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctrl_wr && bus_wdata[0])) |=> flag);

  p_timeout_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> flag);

  p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_o && !wave_sel && clk_sel && !bus_wr) |=> !ext_o);

  p_square_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !timeout) |=> $stable(sq));

  p_idle_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !$rose(flag));

endmodule

// File: tb/periodic_wakeup_timer_bench.sv
module periodic_wakeup_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic bus_wr = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o, ext_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  periodic_wakeup_timer u_periodic_wakeup_timer (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .ext_o(ext_o));

  always #5 clk = ~clk;
  initial begin #3; forever #40 slow_clk = ~slow_clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic idle(input logic sel, input logic [15:0] rl);
    wr(1'b0, 16'h0001);
    wr(1'b0, {8'h00, sel, 7'b0000001});
    wr(1'b1, rl);
  endtask

  task automatic t_reset_r1;
    bus_addr = 1'b0; #1;
    chk(bus_rdata == 16'h0000, "R1 ctrl reset", bus_rdata, 0);
    chk(irq_o == 1'b0 && ext_o == 1'b0, "R1 outputs reset", {irq_o, ext_o}, 0);
    bus_addr = 1'b1; #1;
    chk(bus_rdata == 16'h0000, "R1 reload reset", bus_rdata, 0);
    bus_addr = 1'b0;
    wr(1'b0, 16'hFFFF);
    chk(bus_rdata == 16'h001E, "R1 R2 field layout, select blocked by run-set write", bus_rdata, 16'h001E);
    wr(1'b1, 16'hA5C3);
    bus_addr = 1'b1; #1;
    chk(bus_rdata == 16'hA5C3, "R1 reload readback", bus_rdata, 16'hA5C3);
    bus_addr = 1'b0;
  endtask

  task automatic t_clock_lock_r2;
    wr(1'b0, 16'h0001);
    wr(1'b0, 16'h0080);
    chk(bus_rdata[7] == 1'b1, "R2 select written while stopped", bus_rdata[7], 1);
    wr(1'b0, 16'h0084);
    wr(1'b0, 16'h0004);
    chk(bus_rdata[7] == 1'b1, "R2 select locked while running", bus_rdata[7], 1);
    wr(1'b0, 16'h0000);
    chk(bus_rdata[7] == 1'b1, "R2 select locked on disabling write", bus_rdata[7], 1);
  endtask

  task automatic t_period_pulse_r3;
    int bad = 0;
    idle(1'b1, 16'd3);
    wr(1'b0, 16'h008C);
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (k == 7) chk(bus_rdata[0] == 1'b0, "R3 no flag before 8 cycles", bus_rdata[0], 0);
      if (k == 8) chk(bus_rdata[0] == 1'b1, "R3 flag at 8 cycles", bus_rdata[0], 1);
      if (ext_o != (k % 8 == 0)) bad++;
    end
    chk(bad == 0, "R9 one-cycle pulse every period (R3 spacing)", bad, 0);
  endtask

  task automatic t_square_r10;
    int bad = 0;
    idle(1'b1, 16'd1);
    wr(1'b0, 16'h009C);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (ext_o != ((k / 4) % 2 == 1)) bad++;
    end
    chk(bad == 0, "R10 square wave toggles at each timeout", bad, 0);
  endtask

  task automatic t_slow_r4;
    int n = 0, width = 0, low = 0;
    idle(1'b0, 16'd1);
    wr(1'b0, 16'h000C);
    while (!ext_o && n < 300) begin @(negedge clk); n++; end
    while (ext_o && width < 300) begin @(negedge clk); width++; end
    while (!ext_o && low < 300) begin @(negedge clk); low++; end
    chk(width == 8, "R4 pulse lasts one slow tick", width, 8);
    chk(width + low == 32, "R4 period is 4 slow edges", width + low, 32);
  endtask

  task automatic t_collision_r6;
    idle(1'b1, 16'd0);
    wr(1'b0, 16'h0084);
    repeat (3) @(negedge clk);
    wr(1'b0, 16'h0085);
    chk(bus_rdata[0] == 1'b1, "R6 timeout wins over clear", bus_rdata[0], 1);
    wr(1'b0, 16'h0085);
    chk(bus_rdata[0] == 1'b0, "R5 clear between timeouts", bus_rdata[0], 0);
  endtask

  task automatic t_w1c_r5;
    repeat (2) @(negedge clk);
    wr(1'b0, 16'h0080);
    chk(bus_rdata[0] == 1'b1, "R5 writing 0 keeps flag", bus_rdata[0], 1);
    wr(1'b0, 16'h0081);
    chk(bus_rdata[0] == 1'b0, "R5 writing 1 clears flag", bus_rdata[0], 0);
  endtask

  task automatic t_irq_r7;
    idle(1'b1, 16'd0);
    wr(1'b0, 16'h0084);
    repeat (4) @(negedge clk);
    chk(bus_rdata[0] == 1'b1 && irq_o == 1'b0, "R7 no irq while disabled", irq_o, 0);
    wr(1'b0, 16'h0006);
    chk(irq_o == 1'b1, "R7 irq with flag and enable", irq_o, 1);
    wr(1'b0, 16'h0003);
    wr(1'b0, 16'h0003);
    chk(irq_o == 1'b0, "R7 irq drops with flag", irq_o, 0);
  endtask

  task automatic t_ext_gate_r8;
    int highs = 0;
    idle(1'b1, 16'd0);
    wr(1'b0, 16'h0084);
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (ext_o) highs++; end
    chk(highs == 0, "R8 output low without external enable", highs, 0);
  endtask

  task automatic t_idle_r11;
    int bad = 0;
    idle(1'b1, 16'd1);
    wr(1'b0, 16'h0088);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (bus_rdata[0] || ext_o) bad++;
    end
    chk(bad == 0, "R11 R8 no timeout and low output while stopped", bad, 0);
    wr(1'b0, 16'h008C);
    repeat (2) @(negedge clk);
    wr(1'b0, 16'h0088);
    wr(1'b0, 16'h008C);
    bad = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (ext_o != (k == 4)) bad++;
    end
    chk(bad == 0, "R11 full period after re-enable", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_clock_lock_r2();
    t_period_pulse_r3();
    t_square_r10();
    t_slow_r4();
    t_collision_r6();
    t_w1c_r5();
    t_irq_r7();
    t_ext_gate_r8();
    t_idle_r11();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule